// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit serves one processor's interface to an interrupt distributor. It tracks which interrupt that processor is handling now (the running ID), the priority of that interrupt, and a chain of interrupts that were preempted to reach it. Each interrupt source has one link slot, and that slot holds the ID that was running when the source was taken. An acknowledge request takes the candidate offered by the priority selector if that candidate is more urgent than the running interrupt. The unit then returns the taken ID, or the spurious code 1023, and sends a pulse that clears the source's pending state.

A completion write names an interrupt by the low ten bits of its data word. If the named ID is the running one, its predecessor becomes the running interrupt again. If it names an interrupt deeper in the chain, a multi-cycle walk follows the links from the running interrupt, finds the link that points at the named ID, and splices that ID out. For a level-triggered source whose input is still high, whose enable is set and which targets this processor, the completion also sends a pulse that sets it pending again.

The controller has two states. `S_IDLE` accepts requests. It takes the transition IDLE→WALK when a completion names an ID other than the running one. `S_WALK` performs one link step per cycle and raises `busy`. It takes the transition WALK→IDLE when the chain ends (a link of 1023), when the splice is done, or when the step bound is reached.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100 (one above the largest PRIO_W-bit value), `busy` is low and no pulse or response is asserted.
- R2: An accepted acknowledge whose candidate ID is 1023, or whose candidate priority is not strictly below the running priority, responds on the next cycle with `ack_valid` high and `ack_id` = 1023. The running ID, the running priority and the chain are left unchanged, and no clear pulse is sent.
- R3: An accepted acknowledge that passes that test responds on the next cycle with `ack_id` equal to the candidate. In the same cycle the candidate becomes the running ID, its priority becomes the running priority, and the previous running ID is stored as the candidate's predecessor.
- R4: A successful acknowledge sends a one-cycle `clr_valid` pulse in the same cycle as its response. The pulse carries `clr_id` = the taken ID, and `clr_all_cpus` = `cand_one_of_n` (1 = clear for every processor, 0 = this processor only).
- R5: A completion is ignored when the running ID is 1023: there is no pulse and no state change. The completed ID is taken from `eoi_word[9:0]` only, and bits 31:10 have no effect.
- R6: A completion of ID k, made while some interrupt is running, sends a one-cycle `set_valid` pulse with `set_id` = k on the next cycle when all of these hold: `src_edge[k]`=0, `src_enable[k]`=1, `src_level[k]`=1 and `src_to_cpu[k]`=1. In every other case no pulse is sent.
- R7: Completing the running ID makes its stored predecessor the running ID on the next cycle. The running priority becomes that predecessor's priority from `prio_flat` (bits k*PRIO_W upward), or 0x100 when the predecessor is 1023.
- R8: Completing an ID other than the running one raises `busy` from the next cycle and keeps the running ID unchanged. The walk removes that ID from the chain so that later completions restore the remaining interrupts in nesting order. The walk lasts at most NIRQ cycles, and an ID not found in the chain leaves the chain unchanged.
- R9: While `busy` is high, acknowledge and completion requests are not accepted and produce no response or pulse. In `S_IDLE`, an acknowledge takes precedence over a completion presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request |
| cand_id | input | 10 | Highest pending ID from the priority selector (1023 = none) |
| cand_prio | input | PRIO_W | Priority of `cand_id` |
| cand_one_of_n | input | 1 | Candidate uses 1-of-N handling |
| eoi_req | input | 1 | Completion request |
| eoi_word | input | 32 | Completion data; bits 9:0 hold the ID |
| src_enable | input | NIRQ | Per-source enable for this processor |
| src_level | input | NIRQ | Per-source input level |
| src_edge | input | NIRQ | Per-source edge-triggered flag |
| src_to_cpu | input | NIRQ | Source targets this processor |
| prio_flat | input | NIRQ*PRIO_W | Per-source priorities, packed |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Taken ID or 1023 |
| clr_valid | output | 1 | Pending-clear pulse |
| clr_id | output | 10 | ID to clear |
| clr_all_cpus | output | 1 | Clear for all processors |
| set_valid | output | 1 | Pending-set pulse |
| set_id | output | 10 | ID to set pending for this processor |
| run_id | output | 10 | Running ID |
| run_prio | output | PRIO_W+1 | Running priority |
| busy | output | 1 | Chain walk in progress |

## Verification
The hardest case to reach is a completion that names an interrupt buried in the middle or at the bottom of a preemption chain. The chain can only be built with acknowledges of strictly rising urgency, and the walk can only be started by a completion that does not name the running interrupt. The bench sweeps every chain depth from one to four and every completion position. It then unwinds the rest of the chain and compares each restored running ID and priority against a stack model. While the walk keeps `busy` high, the bench also presents a competing acknowledge and checks that it is not accepted.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    typedef enum logic [0:0] {
        S_IDLE,
        S_WALK
    } ack_state_e;
endpackage

// File: rtl/irq_link_store.sv
module irq_link_store
    import irq_ack_pkg::*;
#(
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_addr,
    input  logic [ID_W-1:0] wr_data,
    input  logic [ID_W-1:0] rd0_addr,
    output logic [ID_W-1:0] rd0_data,
    input  logic [ID_W-1:0] rd1_addr,
    output logic [ID_W-1:0] rd1_data,
    input  logic [ID_W-1:0] rd2_addr,
    output logic [ID_W-1:0] rd2_data
);
    localparam int IXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NIRQ);

    logic [ID_W-1:0] slot [NIRQ];

    for (genvar g = 0; g < NIRQ; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= NO_IRQ;
            end else if (wr_en && wr_addr == ID_W'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    function automatic logic [ID_W-1:0] peek(input logic [ID_W-1:0] a);
        return (a < LIMIT) ? slot[a[IXW-1:0]] : NO_IRQ;
    endfunction

    assign rd0_data = peek(rd0_addr);
    assign rd1_data = peek(rd1_addr);
    assign rd2_data = peek(rd2_addr);
endmodule

// File: rtl/irq_prio_fetch.sv
module irq_prio_fetch
    import irq_ack_pkg::*;
#(
    parameter int NIRQ   = 32,
    parameter int PRIO_W = 8
) (
    input  logic [NIRQ*PRIO_W-1:0] prio_flat,
    input  logic [ID_W-1:0]        id,
    output logic [PRIO_W:0]        prio
);
    localparam int IXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NIRQ);
    localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;

    logic [IXW-1:0] ix;
    assign ix = id[IXW-1:0];

    always_comb begin
        if (id < LIMIT) begin
            prio = {1'b0, prio_flat[ix*PRIO_W +: PRIO_W]};
        end else begin
            prio = IDLE_PRIO;
        end
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NIRQ   = 32,
    parameter int PRIO_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_req,
    input  logic [ID_W-1:0]        cand_id,
    input  logic [PRIO_W-1:0]      cand_prio,
    input  logic                   cand_one_of_n,
    input  logic                   eoi_req,
    input  logic [31:0]            eoi_word,
    input  logic [NIRQ-1:0]        src_enable,
    input  logic [NIRQ-1:0]        src_level,
    input  logic [NIRQ-1:0]        src_edge,
    input  logic [NIRQ-1:0]        src_to_cpu,
    input  logic [NIRQ*PRIO_W-1:0] prio_flat,
    output logic                   ack_valid,
    output logic [ID_W-1:0]        ack_id,
    output logic                   clr_valid,
    output logic [ID_W-1:0]        clr_id,
    output logic                   clr_all_cpus,
    output logic                   set_valid,
    output logic [ID_W-1:0]        set_id,
    output logic [ID_W-1:0]        run_id,
    output logic [PRIO_W:0]        run_prio,
    output logic                   busy
);
    localparam int IXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam int SW  = $clog2(NIRQ + 1);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NIRQ);
    localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;
    localparam logic [SW-1:0] LAST_STEP = SW'(NIRQ - 1);

    ack_state_e state_q, state_d;
    logic [ID_W-1:0] run_q, cur_q, tgt_q;
    logic [PRIO_W:0] rprio_q;
    logic [SW-1:0]   step_q;
    logic            ack_valid_q, clr_valid_q, clr_all_q, set_valid_q;
    logic [ID_W-1:0] ack_id_q, clr_id_q, set_id_q;

    logic [ID_W-1:0] eoi_id;
    logic [IXW-1:0]  eoi_ix;
    logic            idle, ack_take, ack_win;
    logic            eoi_go, eoi_repend, eoi_top, eoi_deep;
    logic            walk_hit, walk_end;
    logic [ID_W-1:0] link_run, link_cur, link_tgt;
    logic [PRIO_W:0] pred_prio;
    logic            wr_en;
    logic [ID_W-1:0] wr_addr, wr_data;

    assign eoi_id = eoi_word[ID_W-1:0];
    assign eoi_ix = eoi_id[IXW-1:0];
    assign idle   = (state_q == S_IDLE);

    // Request acceptance: acknowledge first, completion only when no acknowledge.
    assign ack_take = idle && ack_req;
    assign ack_win  = ack_take && cand_id != NO_IRQ && cand_id < LIMIT
                      && {1'b0, cand_prio} < rprio_q;
    assign eoi_go   = idle && !ack_req && eoi_req && run_q != NO_IRQ;
    assign eoi_repend = eoi_go && eoi_id < LIMIT && !src_edge[eoi_ix]
                        && src_enable[eoi_ix] && src_level[eoi_ix]
                        && src_to_cpu[eoi_ix];
    assign eoi_top  = eoi_go && eoi_id == run_q;
    assign eoi_deep = eoi_go && !eoi_top;

    // Chain walk: one link per cycle, bounded to NIRQ steps.
    assign walk_hit = !idle && tgt_q != NO_IRQ && link_cur == tgt_q;
    assign walk_end = !idle && (link_cur == NO_IRQ || walk_hit || step_q == LAST_STEP);

    assign wr_en   = ack_win || walk_hit;
    assign wr_addr = ack_win ? cand_id : cur_q;
    assign wr_data = ack_win ? run_q : link_tgt;

    irq_link_store #(.NIRQ(NIRQ)) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd0_addr (run_q),
        .rd0_data (link_run),
        .rd1_addr (cur_q),
        .rd1_data (link_cur),
        .rd2_addr (tgt_q),
        .rd2_data (link_tgt)
    );

    irq_prio_fetch #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_prio (
        .prio_flat (prio_flat),
        .id        (link_run),
        .prio      (pred_prio)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (eoi_deep) state_d = S_WALK;
            S_WALK:  if (walk_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= NO_IRQ;
            rprio_q     <= IDLE_PRIO;
            cur_q       <= NO_IRQ;
            tgt_q       <= NO_IRQ;
            step_q      <= '0;
            ack_valid_q <= 1'b0;
            ack_id_q    <= NO_IRQ;
            clr_valid_q <= 1'b0;
            clr_id_q    <= NO_IRQ;
            clr_all_q   <= 1'b0;
            set_valid_q <= 1'b0;
            set_id_q    <= NO_IRQ;
        end else begin
            ack_valid_q <= ack_take;
            ack_id_q    <= ack_win ? cand_id : NO_IRQ;
            clr_valid_q <= ack_win;
            if (ack_win) begin
                clr_id_q  <= cand_id;
                clr_all_q <= cand_one_of_n;
            end
            set_valid_q <= eoi_repend;
            if (eoi_repend) begin
                set_id_q <= eoi_id;
            end
            if (ack_win) begin
                run_q   <= cand_id;
                rprio_q <= {1'b0, cand_prio};
            end else if (eoi_top) begin
                run_q   <= link_run;
                rprio_q <= pred_prio;
            end
            if (eoi_deep) begin
                cur_q  <= run_q;
                tgt_q  <= eoi_id;
                step_q <= '0;
            end else if (!idle) begin
                cur_q  <= link_cur;
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign ack_valid    = ack_valid_q;
    assign ack_id       = ack_id_q;
    assign clr_valid    = clr_valid_q;
    assign clr_id       = clr_id_q;
    assign clr_all_cpus = clr_all_q;
    assign set_valid    = set_valid_q;
    assign set_id       = set_id_q;
    assign run_id       = run_q;
    assign run_prio     = rprio_q;
    assign busy         = (state_q == S_WALK);

    a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        run_q == NO_IRQ |-> rprio_q == IDLE_PRIO);
    a_r2_spur_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_q && ack_id_q == NO_IRQ |-> run_q == $past(run_q));
    a_r3_ack_runs: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_q && ack_id_q != NO_IRQ |-> run_q == ack_id_q);
    a_r4_clr_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_q |-> ack_valid_q && clr_id_q == ack_id_q);
    a_r5_set_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid_q |-> $past(run_q) != NO_IRQ);
    a_r8_walk_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WALK |=> run_q == $past(run_q));
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_valid_q && !set_valid_q);
endmodule

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;
    localparam int CLK_NS = 10;
    localparam int N = 8;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_req = 1'b0, eoi_req = 1'b0, cand_one_of_n = 1'b0;
    logic [9:0] cand_id = 10'd1023;
    logic [PW-1:0] cand_prio = '0;
    logic [31:0] eoi_word = '0;
    logic [N-1:0] src_enable = '0, src_level = '0, src_edge = '0, src_to_cpu = '0;
    logic [N*PW-1:0] prio_flat;
    logic ack_valid, clr_valid, clr_all_cpus, set_valid, busy;
    logic [9:0] ack_id, clr_id, set_id, run_id;
    logic [PW:0] run_prio;

    int n_cmp = 0;
    int n_bad = 0;
    int stk [8];
    int depth = 0;

    always #(CLK_NS/2) clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_prio
        assign prio_flat[g*PW +: PW] = PW'(g * 16);
    end

    irq_ack_unit #(.NIRQ(N), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .cand_id(cand_id),
        .cand_prio(cand_prio), .cand_one_of_n(cand_one_of_n),
        .eoi_req(eoi_req), .eoi_word(eoi_word), .src_enable(src_enable),
        .src_level(src_level), .src_edge(src_edge), .src_to_cpu(src_to_cpu),
        .prio_flat(prio_flat), .ack_valid(ack_valid), .ack_id(ack_id),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_all_cpus(clr_all_cpus),
        .set_valid(set_valid), .set_id(set_id), .run_id(run_id),
        .run_prio(run_prio), .busy(busy)
    );

    function automatic int pr(int id);
        return (id >= N) ? 256 : id * 16;
    endfunction
    function automatic int top_id();
        return (depth == 0) ? 1023 : stk[depth-1];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_run(string req);
        chk({req, " run_id"}, 32'(run_id), 32'(top_id()));
        chk({req, " run_prio"}, 32'(run_prio), 32'(pr(top_id())));
    endtask

    task automatic do_ack(int id, int prio, logic onen, int exp_id);
        cand_id = 10'(id); cand_prio = PW'(prio); cand_one_of_n = onen;
        ack_req = 1'b1;
        @(posedge clk); @(negedge clk);
        ack_req = 1'b0;
        chk("R3 ack_valid", 32'(ack_valid), 1);
        chk(exp_id == 1023 ? "R2 spurious id" : "R3 ack id", 32'(ack_id), 32'(exp_id));
        chk("R4 clr_valid", 32'(clr_valid), 32'(exp_id != 1023));
        if (exp_id != 1023) begin
            chk("R4 clr_id", 32'(clr_id), 32'(exp_id));
            chk("R4 clr_all_cpus", 32'(clr_all_cpus), 32'(onen));
            stk[depth] = exp_id;
            depth++;
        end
        check_run(exp_id == 1023 ? "R2" : "R3");
    endtask

    task automatic do_eoi(int id, logic [21:0] hi, int exp_set);
        int pos;
        bit deep;
        deep = (depth != 0) && (id != top_id());
        eoi_word = {hi, 10'(id)};
        eoi_req = 1'b1;
        @(posedge clk); @(negedge clk);
        eoi_req = 1'b0;
        chk("R6 set_valid", 32'(set_valid), 32'(exp_set));
        if (exp_set != 0) chk("R6 set_id", 32'(set_id), 32'(id));
        chk("R8 busy after deep completion", 32'(busy), 32'(deep));
        if (busy) begin
            cand_id = 10'd0; cand_prio = '0; ack_req = 1'b1;
            @(posedge clk); @(negedge clk);
            ack_req = 1'b0;
            chk("R9 ack ignored while busy", 32'(ack_valid), 0);
        end
        for (int w = 0; w < 40 && busy; w++) begin
            @(posedge clk); @(negedge clk);
        end
        chk("R8 walk ended", 32'(busy), 0);
        pos = -1;
        for (int k = 0; k < depth; k++) if (stk[k] == id) pos = k;
        if (pos >= 0) begin
            for (int k = pos; k < depth - 1; k++) stk[k] = stk[k+1];
            depth--;
        end
        check_run(deep ? "R8" : "R7");
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 run_id", 32'(run_id), 1023);
        chk("R1 run_prio", 32'(run_prio), 256);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 ack_valid", 32'(ack_valid), 0);
        chk("R1 pulses", 32'({clr_valid, set_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: completion with nothing running is ignored
        src_enable = '1; src_level = '1; src_to_cpu = '1;
        do_eoi(3, 22'h3ffff, 0);
        src_enable = '0; src_level = '0; src_to_cpu = '0;

        // R6 sweep over the four re-pend conditions, upper data bits set (R5)
        for (int c = 0; c < 16; c++) begin
            src_edge[3] = c[0]; src_enable[3] = c[1];
            src_level[3] = c[2]; src_to_cpu[3] = c[3];
            do_ack(3, pr(3), c[0], 3);
            do_eoi(3, 22'(32'h2a5a5 ^ c), (!c[0] && c[1] && c[2] && c[3]) ? 1 : 0);
        end
        src_edge = '0; src_enable = '0; src_level = '0; src_to_cpu = '0;

        // R7/R8 chain sweep: every depth and completion position
        for (int d = 1; d <= 4; d++) begin
            for (int p = 0; p < d; p++) begin
                for (int k = 0; k < d; k++) do_ack(7 - k, pr(7 - k), p[0], 7 - k);
                do_ack(top_id(), pr(top_id()), 1'b0, 1023);   // R2 equal priority
                do_ack(1023, 0, 1'b0, 1023);                  // R2 none pending
                do_ack(7, pr(7) + 1, 1'b0, 1023);             // R2 less urgent
                if (d >= 2) do_eoi(1, 22'h0, 0);              // R8 not in chain
                do_eoi(stk[p], 22'h0, 0);
                while (depth > 0) do_eoi(top_id(), 22'h0, 0);
                do_eoi(5, 22'h0, 0);                          // R5 idle again
            end
        end

        // R9: acknowledge wins over a same-cycle completion
        do_ack(6, pr(6), 1'b0, 6);
        cand_id = 10'd2; cand_prio = PW'(pr(2)); eoi_word = 32'd6;
        ack_req = 1'b1; eoi_req = 1'b1;
        @(posedge clk); @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        chk("R9 ack taken over eoi", 32'(ack_id), 2);
        stk[depth] = 2; depth++;
        check_run("R9");
        while (depth > 0) do_eoi(top_id(), 22'h0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule